// File: doc/BRIEF.md
# DMX512 Packet Transmitter

This block produces a complete DMX512-style lighting packet on a single serial line. It runs from a fast system clock. A one-cycle start strobe while the block is idle sets off a packet. The line first goes low for a counted break. It then goes high for a counted mark-after-break. After that comes a run of 11-bit slots at a fixed bit rate. Each slot has one low start bit, eight data bits sent least significant bit first, and two high stop bits.

The first slot always carries a fixed start code. The channel slots that follow take their bytes in one of two ways:
- In handshake mode, the block takes each byte from a valid/ready interface at the moment that slot's start bit would begin.
- In fill mode, every channel slot repeats one latched byte.

Between packets, and while it waits for data, the line rests at mark (high). A bit-period counter runs only while slots are being sent. The bit period is the clock frequency divided by the baud rate, which is 64 cycles for 16 MHz and 250 kbit/s.

Top module: `dmx_tx`

## Requirements
- R1: After reset the line is high, busy is low and data_ready is low, and all three stay so until a start strobe arrives.
- R2: A start strobe sampled while idle sets busy and drives the line low in the next cycle. The line then stays low for exactly BREAK_BITS × BIT_CYCLES cycles (22 bit times by default).
- R3: After the break the line is high for exactly MAB_BITS × BIT_CYCLES cycles (2 bit times by default).
- R4: Each slot lasts 11 × BIT_CYCLES cycles. Each bit holds for BIT_CYCLES cycles, and the bit-period counter is zero whenever no packet is in progress. Bit 0 of a slot is low. Bits 1 to 8 are the data byte, least significant bit first. Bits 9 and 10 are high.
- R5: The first slot after the mark-after-break carries START_CODE (default 8'h00) and needs no handshake.
- R6: The number of channel slots after the start code is chan_count, sampled with the start strobe. A value of 0 gives 1 slot, and values above MAX_SLOTS (512) give 512 slots.
- R7: When fill_en is high with the start strobe, every channel slot carries fill_byte (sampled with the strobe). data_ready stays low, and each slot's start bit follows the previous slot's second stop bit with no gap (start bits 11 × BIT_CYCLES cycles apart).
- R8: In handshake mode a byte is taken in a cycle where data_valid and data_ready are both high. data_ready is high only in the last cycle of a slot with more channel slots due, or while waiting for data. A byte offered by that cycle starts its slot in the next cycle, with no gap.
- R9: If no byte is valid when a channel slot is due, the line holds high and data_ready stays high. The slot's start bit begins in the cycle after the handshake.
- R10: A start strobe while busy is ignored. The packet in progress keeps its slot count, and no new break follows it.
- R11: In the cycle after the last slot's second stop bit, busy is low and the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a packet |
| chan_count | input | 10 | Number of channel slots, sampled with start |
| fill_en | input | 1 | Selects fill mode, sampled with start |
| fill_byte | input | 8 | Byte repeated in fill mode, sampled with start |
| data_valid | input | 1 | A channel byte is offered |
| data_byte | input | 8 | Offered channel byte |
| data_ready | output | 1 | The block takes the offered byte this cycle |
| busy | output | 1 | A packet is in progress |
| dmx_line | output | 1 | Serial output, high is mark |

## Verification
The bench runs four packets.

1. A handshake packet with distinct, asymmetric bytes. It separates LSB-first from MSB-first order and shows the start code ahead of channel data. Two of its bytes are offered before they are due, which tells a seamless slot join from one with an idle gap. The third is offered late, which exposes any corruption or premature start bit while the line waits.
2. A fill packet of five slots. It checks constant 11-bit start-bit spacing, and a stray start strobe lands in the middle of it.
3. A fill packet with a channel count of zero.
4. A fill packet with a channel count of 600.

The last two separate correct clamping at both ends from off-by-one slot counts. Mid-bit sampling of every bit, together with exact run lengths of the break and mark-after-break, tells a correct bit period from a neighbouring one.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int FRAME_BITS = 11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_MAB,
        ST_SLOT,
        ST_WAIT
    } dmx_state_e;

    typedef struct packed {
        logic [FRAME_BITS-1:0] bits;
        logic [3:0]            idx;
    } frame_t;

    // Start bit in position 0, data LSB next, two stop bits on top.
    function automatic logic [FRAME_BITS-1:0] make_frame(input logic [7:0] b);
        return {2'b11, b, 1'b0};
    endfunction

endpackage

// File: rtl/dmx_bit_timer.sv
module dmx_bit_timer #(
    parameter int BIT_CYCLES = 64,
    localparam int CNT_W = $clog2(BIT_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic             bit_end,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CYCLES - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign bit_end = run && (cnt == LAST);
endmodule

// File: rtl/dmx_gap_timer.sv
module dmx_gap_timer #(
    parameter int GAP_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             done
);
    logic [GAP_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/dmx_slot_shifter.sv
module dmx_slot_shifter
    import dmx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       shift,
    output logic       line_bit,
    output logic       last_bit
);
    frame_t fr;

    always_ff @(posedge clk) begin
        if (rst) begin
            fr.bits <= '1;
            fr.idx  <= '0;
        end else if (load) begin
            fr.bits <= make_frame(load_byte);
            fr.idx  <= '0;
        end else if (shift) begin
            fr.bits <= {1'b1, fr.bits[FRAME_BITS-1:1]};
            fr.idx  <= fr.idx + 1'b1;
        end
    end

    assign line_bit = fr.bits[0];
    assign last_bit = (fr.idx == 4'(FRAME_BITS - 1));
endmodule

// File: rtl/dmx_tx.sv
module dmx_tx
    import dmx_pkg::*;
#(
    parameter int         CLK_HZ     = 16_000_000,
    parameter int         BAUD       = 250_000,
    parameter int         BREAK_BITS = 22,
    parameter int         MAB_BITS   = 2,
    parameter int         MAX_SLOTS  = 512,
    parameter logic [7:0] START_CODE = 8'h00,
    localparam int        CH_W       = $clog2(MAX_SLOTS + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [CH_W-1:0] chan_count,
    input  logic            fill_en,
    input  logic [7:0]      fill_byte,
    input  logic            data_valid,
    input  logic [7:0]      data_byte,
    output logic            data_ready,
    output logic            busy,
    output logic            dmx_line
);
    localparam int BIT_CYCLES = CLK_HZ / BAUD;
    localparam int BIT_W      = $clog2(BIT_CYCLES + 1);
    localparam int BREAK_CYC  = BREAK_BITS * BIT_CYCLES;
    localparam int MAB_CYC    = MAB_BITS * BIT_CYCLES;
    localparam int GAP_MAX    = (BREAK_CYC > MAB_CYC) ? BREAK_CYC : MAB_CYC;
    localparam int GAP_W      = $clog2(GAP_MAX + 1);

    dmx_state_e      state_q, state_d;
    logic [CH_W-1:0] slots_q, slots_d;
    logic            fill_q;
    logic [7:0]      fill_byte_q;

    logic             bit_end;
    logic [BIT_W-1:0] bit_cnt;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             gap_done;
    logic             sh_load, sh_shift, sh_bit, sh_last;
    logic [7:0]       sh_byte;

    function automatic logic [CH_W-1:0] clamp_ch(input logic [CH_W-1:0] n);
        if (n == '0)
            return CH_W'(1);
        else if (n > CH_W'(MAX_SLOTS))
            return CH_W'(MAX_SLOTS);
        else
            return n;
    endfunction

    dmx_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state_q == ST_SLOT),
        .bit_end (bit_end),
        .cnt     (bit_cnt)
    );

    dmx_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (gap_val),
        .done     (gap_done)
    );

    dmx_slot_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .load_byte (sh_byte),
        .shift     (sh_shift),
        .line_bit  (sh_bit),
        .last_bit  (sh_last)
    );

    always_comb begin
        state_d    = state_q;
        slots_d    = slots_q;
        gap_load   = 1'b0;
        gap_val    = '0;
        sh_load    = 1'b0;
        sh_byte    = START_CODE;
        sh_shift   = 1'b0;
        data_ready = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_BREAK;
                    gap_load = 1'b1;
                    gap_val  = GAP_W'(BREAK_CYC - 1);
                    slots_d  = clamp_ch(chan_count);
                end
            end
            ST_BREAK: begin
                if (gap_done) begin
                    state_d  = ST_MAB;
                    gap_load = 1'b1;
                    gap_val  = GAP_W'(MAB_CYC - 1);
                end
            end
            ST_MAB: begin
                if (gap_done) begin
                    state_d = ST_SLOT;
                    sh_load = 1'b1;
                    sh_byte = START_CODE;
                end
            end
            ST_SLOT: begin
                if (bit_end) begin
                    if (!sh_last) begin
                        sh_shift = 1'b1;
                    end else if (slots_q == '0) begin
                        state_d = ST_IDLE;
                    end else if (fill_q) begin
                        sh_load = 1'b1;
                        sh_byte = fill_byte_q;
                        slots_d = slots_q - 1'b1;
                    end else begin
                        data_ready = 1'b1;
                        if (data_valid) begin
                            sh_load = 1'b1;
                            sh_byte = data_byte;
                            slots_d = slots_q - 1'b1;
                        end else begin
                            state_d = ST_WAIT;
                        end
                    end
                end
            end
            ST_WAIT: begin
                data_ready = 1'b1;
                if (data_valid) begin
                    state_d = ST_SLOT;
                    sh_load = 1'b1;
                    sh_byte = data_byte;
                    slots_d = slots_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            slots_q     <= '0;
            fill_q      <= 1'b0;
            fill_byte_q <= '0;
        end else begin
            state_q <= state_d;
            slots_q <= slots_d;
            if (state_q == ST_IDLE && start) begin
                fill_q      <= fill_en;
                fill_byte_q <= fill_byte;
            end
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign dmx_line = (state_q == ST_BREAK) ? 1'b0 :
                      (state_q == ST_SLOT)  ? sh_bit : 1'b1;
endmodule

// File: rtl/dmx_tx_checker.sv
module dmx_tx_checker #(
    parameter int BIT_CYCLES = 64,
    parameter int BIT_W      = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             data_valid,
    input logic             data_ready,
    input logic             busy,
    input logic             dmx_line,
    input logic [BIT_W-1:0] bit_cnt
);
    p_idle_mark_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> dmx_line);

    p_break_begins_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !dmx_line));

    p_timer_range_r4: assert property (@(posedge clk) disable iff (rst)
        bit_cnt < BIT_W'(BIT_CYCLES));

    p_timer_held_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bit_cnt == '0));

    p_ready_busy_r8: assert property (@(posedge clk) disable iff (rst)
        data_ready |-> busy);

    p_take_start_r8: assert property (@(posedge clk) disable iff (rst)
        (data_ready && data_valid) |=> !dmx_line);

    p_wait_mark_r9: assert property (@(posedge clk) disable iff (rst)
        (data_ready && !data_valid) |=> (dmx_line && data_ready));
endmodule

bind dmx_tx dmx_tx_checker #(.BIT_CYCLES(BIT_CYCLES), .BIT_W(BIT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .data_valid (data_valid),
    .data_ready (data_ready),
    .busy       (busy),
    .dmx_line   (dmx_line),
    .bit_cnt    (bit_cnt)
);

// File: tb/dmx_tx_bench.sv
module dmx_tx_bench;
    localparam int T     = 8;
    localparam int BRK   = 22;
    localparam int MAB   = 2;
    localparam int CH_W  = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [CH_W-1:0] chan_count = '0;
    logic            fill_en = 1'b0;
    logic [7:0]      fill_byte = '0;
    logic            data_valid = 1'b0;
    logic [7:0]      data_byte = '0;
    logic            data_ready, busy, dmx_line;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  done = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dmx_tx #(.CLK_HZ(T), .BAUD(1), .BREAK_BITS(BRK), .MAB_BITS(MAB)) u_dmx_tx (
        .clk(clk), .rst(rst), .start(start), .chan_count(chan_count),
        .fill_en(fill_en), .fill_byte(fill_byte), .data_valid(data_valid),
        .data_byte(data_byte), .data_ready(data_ready), .busy(busy),
        .dmx_line(dmx_line)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Monitor: measures break/MAB, decodes each slot at mid-bit, compares with queue.
    task automatic monitor(input int nslots, input int b2b_upto);
        int n;
        int prev_start;
        int this_start;
        logic [10:0] bits;
        while (dmx_line !== 1'b0) @(negedge clk);
        n = 0;
        while (dmx_line === 1'b0) begin n++; @(negedge clk); end
        check(n == BRK*T, "R2 break length", n, BRK*T);
        n = 0;
        while (dmx_line === 1'b1) begin n++; @(negedge clk); end
        check(n == MAB*T, "R3 mark-after-break length", n, MAB*T);
        prev_start = 0;
        for (int s = 0; s < nslots; s++) begin
            while (dmx_line !== 1'b0) @(negedge clk);
            this_start = cyc;
            if (s > 0 && s <= b2b_upto)
                check(this_start - prev_start == 11*T, "R7/R8 slot spacing",
                      this_start - prev_start, 11*T);
            prev_start = this_start;
            for (int b = 0; b < 11; b++) begin
                repeat ((b == 0) ? T/2 : T) @(negedge clk);
                bits[b] = dmx_line;
            end
            check(bits[0] == 1'b0 && bits[10:9] == 2'b11, "R4 slot framing",
                  int'({bits[10:9], bits[0]}), 6);
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected slot", s, nslots);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(bits[8:1] == e, (s == 0) ? "R5 start code" : "R4/R7/R8 slot byte",
                      int'(bits[8:1]), int'(e));
            end
            repeat (T/2) @(negedge clk);
        end
        check(busy == 1'b0 && dmx_line == 1'b1, "R11 end of packet",
              int'({busy, dmx_line}), 1);
        n = 0;
        repeat (4*T) begin
            if (busy !== 1'b0 || dmx_line !== 1'b1) n++;
            @(negedge clk);
        end
        check(n == 0, "R6/R10 no extra slot or break after packet", n, 0);
    endtask

    task automatic pulse_start(input logic [CH_W-1:0] cnt, input bit fill, input logic [7:0] fb);
        chan_count = cnt; fill_en = fill; fill_byte = fb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && dmx_line == 1'b0, "R2 break starts after strobe",
              int'({busy, dmx_line}), 2);
    endtask

    task automatic send_byte(input logic [7:0] b, input int pre_delay, input bit check_wait);
        repeat (pre_delay) @(negedge clk);
        if (check_wait)
            check(data_ready == 1'b1 && dmx_line == 1'b1, "R9 line at mark while waiting",
                  int'({data_ready, dmx_line}), 3);
        data_valid = 1'b1;
        data_byte  = b;
        while (data_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        data_valid = 1'b0;
        if (check_wait)
            check(dmx_line == 1'b0, "R9 start bit after late handshake", int'(dmx_line), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(dmx_line == 1'b1 && busy == 1'b0 && data_ready == 1'b0, "R1 reset state",
              int'({dmx_line, busy, data_ready}), 4);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check(dmx_line == 1'b1 && busy == 1'b0 && data_ready == 1'b0, "R1 idle state",
              int'({dmx_line, busy, data_ready}), 4);

        // Packet A: handshake mode, three channels, last one late.
        exp_q = '{8'h00, 8'hA5, 8'h3C, 8'h81};
        fork
            monitor(4, 2);
            begin
                pulse_start(10'd3, 1'b0, 8'h00);
                send_byte(8'hA5, 0, 1'b0);
                send_byte(8'h3C, 0, 1'b0);
                send_byte(8'h81, 11*T + 40, 1'b1);
            end
        join

        // Packet B: fill mode, five channels, stray strobe mid-packet (R10).
        exp_q = '{8'h00, 8'h96, 8'h96, 8'h96, 8'h96, 8'h96};
        fork
            monitor(6, 5);
            begin
                pulse_start(10'd5, 1'b1, 8'h96);
                repeat (400) @(negedge clk);
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check(busy == 1'b1, "R10 strobe while busy keeps packet", int'(busy), 1);
            end
            begin
                int rd = 0;
                repeat (BRK*T + MAB*T + 6*11*T) begin
                    @(negedge clk);
                    if (data_ready) rd++;
                end
                check(rd == 0, "R7 no ready in fill mode", rd, 0);
            end
        join

        // Packet C: channel count zero gives one slot.
        exp_q = '{8'h00, 8'h5E};
        fork
            monitor(2, 1);
            pulse_start(10'd0, 1'b1, 8'h5E);
        join

        // Packet D: channel count above maximum clamps to 512.
        exp_q = {};
        exp_q.push_back(8'h00);
        for (int i = 0; i < 512; i++) exp_q.push_back(8'hC3);
        fork
            monitor(513, 512);
            pulse_start(10'd600, 1'b1, 8'hC3);
        join
        check(exp_q.size() == 0, "R6 all clamped slots sent", exp_q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule